// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execute unit of a small load/store RISC core. In one cycle it combines a first operand and a second operand that has already passed through the core's shifter, under a 4-bit operation code. It produces the data result, a write strobe for the destination register and the next value of the four condition flags: negative, zero, carry and overflow. The flags themselves are held in a register inside the block, which is loaded at the clock edge.

Sixteen operations are decoded. Six are arithmetic: add and subtract, reverse subtract, and the carry-chained form of each. Six are logic and move operations, among them bit-clear and the inverted move. Four are flag-only forms (compare, compare-negated, test and test-equal) that never write a register and always update the flags when issued. A set-flags input decides whether the other twelve operations touch the flags. Logic operations take their carry from the shifter and leave overflow as it was.

Top module: `dp_alu`

## Requirements
- R1: Arithmetic results are: opcode 0100 rn+op2; 0101 rn+op2+carry_i; 0010 rn-op2; 0110 rn-op2+carry_i-1; 0011 op2-rn; 0111 op2-rn+carry_i-1. All are taken modulo 2^32.
- R2: Logic results are: 0000 rn AND op2; 0001 rn XOR op2; 1100 rn OR op2; 1101 op2 (rn is ignored); 1110 rn AND NOT op2; 1111 NOT op2.
- R3: The flag-only opcodes 1000 (AND), 1001 (XOR), 1010 (subtract) and 1011 (add) keep rd_we_o low. Their computed value still appears on result_o.
- R4: flags_o = {N,Z,C,V} in bits [3:0]. It loads at the rising edge only when valid_i is high and either set_flags_i is high or the opcode is one of 10xx. Otherwise it holds.
- R5: When the flags update, N takes result bit 31 and Z is 1 exactly when the 32-bit result is zero.
- R6: For arithmetic opcodes, C is the carry out of bit 31. For subtract forms this is the inverted borrow, so 1 means no borrow occurred.
- R7: For arithmetic opcodes, V is 1 on signed two's-complement overflow of the operation.
- R8: For logic, test and move opcodes, C takes shift_carry_i and V keeps its previous value.
- R9: After reset, flags_o is 0000.
- R10: next_flags_o always equals the value flags_o takes at the next rising edge.
- R11: rd_we_o is 1 exactly when valid_i is high and the opcode is not 10xx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | An instruction is issued this cycle |
| opcode_i | input | 4 | Operation code |
| rn_i | input | 32 | First operand |
| op2_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Carry out of the shifter |
| carry_i | input | 1 | Current carry flag used by carry-chained forms |
| set_flags_i | input | 1 | Request a flag update |
| result_o | output | 32 | Data result |
| rd_we_o | output | 1 | Destination register write enable |
| next_flags_o | output | 4 | Flags after this cycle's edge, {N,Z,C,V} |
| flags_o | output | 4 | Registered flags, {N,Z,C,V} |

## Verification
The checker tests several properties on every cycle. Flag-only opcodes and idle cycles never raise the write strobe. The flag register holds whenever no update is enabled and always loads what next_flags_o showed. Updated N and Z agree with the result. A logic update copies the shifter carry and keeps V. The correctness of each arithmetic sum, the carry and borrow convention and the signed-overflow cases cannot be stated as such properties. The bench's scenarios show them against an independent 64-bit model, at edge values such as all-ones plus one, the largest positive value plus one, and equal or reversed subtraction operands.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_sel_e;

  typedef enum logic [2:0] {LG_AND, LG_EOR, LG_ORR, LG_MOV, LG_BIC, LG_MVN} logic_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic       arith;
    logic       no_wb;
    logic       swap;
    logic       inv_b;
    cin_sel_e   cin_sel;
    logic_sel_e lg_sel;
  } dec_t;
endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] opcode_i,
  output dec_t       dec_o
);
  alu_op_e op;
  assign op = alu_op_e'(opcode_i);

  always_comb begin
    dec_o         = '0;
    dec_o.cin_sel = CIN_ZERO;
    dec_o.lg_sel  = LG_AND;
    dec_o.no_wb   = (opcode_i[3:2] == 2'b10);
    unique case (op)
      OP_ADD, OP_CMN: dec_o.arith = 1'b1;
      OP_ADC: begin
        dec_o.arith   = 1'b1;
        dec_o.cin_sel = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        dec_o.arith   = 1'b1;
        dec_o.inv_b   = 1'b1;
        dec_o.cin_sel = CIN_ONE;
      end
      OP_SBC: begin
        dec_o.arith   = 1'b1;
        dec_o.inv_b   = 1'b1;
        dec_o.cin_sel = CIN_FLAG;
      end
      OP_RSB: begin
        dec_o.arith   = 1'b1;
        dec_o.swap    = 1'b1;
        dec_o.inv_b   = 1'b1;
        dec_o.cin_sel = CIN_ONE;
      end
      OP_RSC: begin
        dec_o.arith   = 1'b1;
        dec_o.swap    = 1'b1;
        dec_o.inv_b   = 1'b1;
        dec_o.cin_sel = CIN_FLAG;
      end
      OP_AND, OP_TST: dec_o.lg_sel = LG_AND;
      OP_EOR, OP_TEQ: dec_o.lg_sel = LG_EOR;
      OP_ORR:         dec_o.lg_sel = LG_ORR;
      OP_MOV:         dec_o.lg_sel = LG_MOV;
      OP_BIC:         dec_o.lg_sel = LG_BIC;
      OP_MVN:         dec_o.lg_sel = LG_MVN;
      default:        dec_o.lg_sel = LG_AND;
    endcase
  end
endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    // overflow: like-signed inputs giving an opposite-signed sum
    ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic_sel_e       sel_i,
  input  logic [WIDTH-1:0] rn_i,
  input  logic [WIDTH-1:0] op2_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = rn_i & op2_i;
      LG_EOR:  res_o = rn_i ^ op2_i;
      LG_ORR:  res_o = rn_i | op2_i;
      LG_MOV:  res_o = op2_i;
      LG_BIC:  res_o = rn_i & ~op2_i;
      LG_MVN:  res_o = ~op2_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flag_reg.sv
module dp_alu_flag_reg
  import dp_alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        opcode_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic [DATA_W-1:0] op2_i,
  input  logic              shift_carry_i,
  input  logic              carry_i,
  input  logic              set_flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              rd_we_o,
  output logic [3:0]        next_flags_o,
  output logic [3:0]        flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  dec_t              dec;
  logic [DATA_W-1:0] opa, opb_raw, opb, sum, lres;
  logic              cin, cout, ovf, upd;
  flags_t            flags_q, flags_calc, flags_d;

  dp_alu_decode i_decode (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  // operand routing: reverse forms swap, subtract forms invert the subtrahend
  always_comb begin
    opa     = dec.swap ? op2_i : rn_i;
    opb_raw = dec.swap ? rn_i  : op2_i;
    opb     = dec.inv_b ? ~opb_raw : opb_raw;
    unique case (dec.cin_sel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = carry_i;
      default:  cin = 1'b0;
    endcase
  end

  dp_alu_adder #(.WIDTH(DATA_W)) i_adder (
    .a_i    (opa),
    .b_i    (opb),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  dp_alu_logic #(.WIDTH(DATA_W)) i_logic (
    .sel_i (dec.lg_sel),
    .rn_i  (rn_i),
    .op2_i (op2_i),
    .res_o (lres)
  );

  assign result_o = dec.arith ? sum : lres;
  assign rd_we_o  = valid_i & ~dec.no_wb;
  assign upd      = valid_i & (set_flags_i | dec.no_wb);

  always_comb begin
    flags_calc.n = result_o[MSB];
    flags_calc.z = ~|result_o;
    flags_calc.c = dec.arith ? cout : shift_carry_i;
    flags_calc.v = dec.arith ? ovf  : flags_q.v;
    flags_d      = upd ? flags_calc : flags_q;
  end

  dp_alu_flag_reg i_flag_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (upd),
    .d_i    (flags_calc),
    .q_o    (flags_q)
  );

  assign next_flags_o = flags_d;
  assign flags_o      = flags_q;
endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        opcode_i,
  input logic              shift_carry_i,
  input logic              set_flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic              rd_we_o,
  input logic [3:0]        next_flags_o,
  input logic [3:0]        flags_o
);
  logic is_flag_only, is_logic;
  assign is_flag_only = (opcode_i[3:2] == 2'b10);
  assign is_logic     = (opcode_i[2:1] == 2'b00) || (opcode_i[3:2] == 2'b11);

  assert_no_write_flag_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_flag_only) |-> !rd_we_o);

  assert_idle_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !rd_we_o);

  assert_flags_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (set_flags_i || is_flag_only)) |=> $stable(flags_o));

  assert_next_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flags_o == $past(next_flags_o)));

  assert_nz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (set_flags_i || is_flag_only)) |=>
      (flags_o[3] == $past(result_o[DATA_W-1])) && (flags_o[2] == ($past(result_o) == '0)));

  assert_logic_cv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (set_flags_i || is_flag_only) && is_logic) |=>
      (flags_o[1] == $past(shift_carry_i)) && (flags_o[0] == $past(flags_o[0])));
endmodule

bind dp_alu dp_alu_checker #(.DATA_W(DATA_W)) i_dp_alu_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .opcode_i      (opcode_i),
  .shift_carry_i (shift_carry_i),
  .set_flags_i   (set_flags_i),
  .result_o      (result_o),
  .rd_we_o       (rd_we_o),
  .next_flags_o  (next_flags_o),
  .flags_o       (flags_o)
);

// File: tb/test_dp_alu.sv
`timescale 1ns/1ps
module test_dp_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic [31:0] rn_i = '0, op2_i = '0;
  logic        shift_carry_i = 1'b0, carry_i = 1'b0, set_flags_i = 1'b0;
  logic [31:0] result_o;
  logic        rd_we_o;
  logic [3:0]  next_flags_o, flags_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
    string       req;
  } item_t;
  item_t sb_q[$];
  logic [3:0] model_fl = 4'b0000;

  always #2 clk_i = ~clk_i;

  dp_alu i_dp_alu (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .rn_i, .op2_i, .shift_carry_i,
    .carry_i, .set_flags_i, .result_o, .rd_we_o, .next_flags_o, .flags_o
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: compute expectation from the requirements, push, drive inputs
  task automatic issue(input logic [3:0] op, input logic [31:0] rn, input logic [31:0] op2,
                       input logic sc, input logic cin, input logic sf, input logic vld,
                       input string req);
    longint u, s, urn, uop, srn, sop, k;
    logic [31:0] r;
    logic c, v, arith;
    item_t it;
    urn = longint'(rn);  uop = longint'(op2);
    srn = longint'($signed(rn)); sop = longint'($signed(op2));
    arith = 1'b1; u = 0; s = 0; c = 1'b0; r = '0;
    case (op)
      4'b0100, 4'b1011: begin u = urn + uop; s = srn + sop; c = (u >= 64'sd4294967296); end
      4'b0101: begin k = cin ? 1 : 0; u = urn + uop + k; s = srn + sop + k; c = (u >= 64'sd4294967296); end
      4'b0010, 4'b1010: begin u = urn - uop; s = srn - sop; c = (u >= 0); end
      4'b0110: begin k = cin ? 0 : 1; u = urn - uop - k; s = srn - sop - k; c = (u >= 0); end
      4'b0011: begin u = uop - urn; s = sop - srn; c = (u >= 0); end
      4'b0111: begin k = cin ? 0 : 1; u = uop - urn - k; s = sop - srn - k; c = (u >= 0); end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      r = u[31:0];
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (op)
        4'b0000, 4'b1000: r = rn & op2;
        4'b0001, 4'b1001: r = rn ^ op2;
        4'b1100: r = rn | op2;
        4'b1101: r = op2;
        4'b1110: r = rn & ~op2;
        default: r = ~op2;
      endcase
      c = sc;
      v = model_fl[0];
    end
    if (vld && (sf || op[3:2] == 2'b10))
      model_fl = {r[31], (r == 32'd0), c, v};
    it.res = r;
    it.we  = vld && (op[3:2] != 2'b10);
    it.fl  = model_fl;
    it.req = req;
    @(negedge clk_i);
    valid_i = vld; opcode_i = op; rn_i = rn; op2_i = op2;
    shift_carry_i = sc; carry_i = cin; set_flags_i = sf;
    sb_q.push_back(it);
  endtask

  // monitor: one item per rising edge, sampled 1 ns after it
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.req, "result", result_o, it.res);
        check("R11", "rd_we", {31'd0, rd_we_o}, {31'd0, it.we});
        check(it.req, "flags", {28'd0, flags_o}, {28'd0, it.fl});
        check("R10", "next_flags", {28'd0, next_flags_o}, {28'd0, it.fl});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R9", "reset flags", {28'd0, flags_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R9", "flags after release", {28'd0, flags_o}, 32'd0);

    // R1 / R6 / R7 arithmetic
    issue(4'b0100, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, 1, "R6 add wrap carry zero");
    issue(4'b0100, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, 1, "R7 add signed overflow");
    issue(4'b0101, 32'h10, 32'h20, 0, 1, 1, 1, "R1 adc carry in");
    issue(4'b0010, 32'h5, 32'h5, 0, 0, 1, 1, "R6 sub equal no borrow");
    issue(4'b0010, 32'h3, 32'h5, 0, 0, 1, 1, "R6 sub borrow");
    issue(4'b0010, 32'h8000_0000, 32'h1, 0, 0, 1, 1, "R7 sub overflow");
    issue(4'b0110, 32'h100, 32'h1, 0, 0, 1, 1, "R1 sbc carry clear");
    issue(4'b0110, 32'h100, 32'h1, 0, 1, 1, 1, "R1 sbc carry set");
    issue(4'b0011, 32'h4, 32'h10, 0, 0, 1, 1, "R1 rsb");
    issue(4'b0111, 32'h4, 32'h10, 0, 0, 1, 1, "R1 rsc carry clear");
    issue(4'b0111, 32'h10, 32'h4, 0, 1, 1, 1, "R1 rsc borrow");
    // set V, then logic ops must keep it (R8)
    issue(4'b0100, 32'h4000_0000, 32'h4000_0000, 0, 0, 1, 1, "R7 add positive overflow");
    issue(4'b0000, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 1, 0, 1, 1, "R8 and keeps v");
    issue(4'b0001, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 0, 1, 1, "R5 eor zero");
    issue(4'b1100, 32'h0000_00F0, 32'h8000_000F, 1, 0, 1, 1, "R2 orr");
    issue(4'b1101, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 1, 1, "R2 mov ignores rn");
    issue(4'b1110, 32'hFFFF_FFFF, 32'h0000_FFFF, 1, 0, 1, 1, "R2 bic");
    issue(4'b1111, 32'h5555_5555, 32'h0000_0000, 0, 0, 1, 1, "R2 mvn");
    // flag-only forms, set_flags low (R3, R4)
    issue(4'b1010, 32'h7, 32'h9, 0, 0, 0, 1, "R3 cmp forced flags");
    issue(4'b1011, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 1, "R3 cmn forced flags");
    issue(4'b1000, 32'h0F, 32'hF0, 1, 0, 0, 1, "R3 tst forced flags");
    issue(4'b1001, 32'h8000_0001, 32'h1, 0, 0, 0, 1, "R3 teq forced flags");
    // no update when set_flags low or not valid (R4, R11)
    issue(4'b0100, 32'hFFFF_FFFF, 32'h1, 1, 0, 0, 1, "R4 add without set");
    issue(4'b1010, 32'h1, 32'h2, 1, 0, 1, 0, "R4 invalid cmp holds");
    issue(4'b0010, 32'h1, 32'h2, 0, 0, 1, 0, "R11 invalid sub no write");
    issue(4'b1101, 32'h0, 32'h0, 1, 0, 1, 1, "R5 mov zero");
    @(negedge clk_i);
    valid_i = 1'b0;
    wait (sb_q.size() == 0);
    @(posedge clk_i); #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule